// File: doc/BRIEF.md
# Debug Trigger Match Sequencer

This block converts comparator hits into moves of a small debug state machine. Each comparator channel reports a one-cycle match pulse and carries a mode bit. A channel in forced mode makes the sequencer move a fixed number of cycles after the pulse. A channel in tagged mode only marks the instruction that is being fetched. The move then happens when that instruction reaches the execute stage, which the core signals with an execute strobe. A software trigger write can also end the session. Its effect depends on how the session is aligned. With begin alignment it jumps to the final state. With end alignment it disarms the unit and asks the core for a breakpoint.

The machine has five states: Disarmed (code 0), Armed-1 (code 1), Armed-2 (code 2), Armed-3 (code 3) and Final (code 4). The named transitions are:
- **Arm**: any state to Armed-1.
- **Forced hit** and **Tag hit**: an armed state to the state that its configuration field selects for the winning channel.
- **Begin trigger**: a non-disarmed state to Final.
- **End trigger**: a non-disarmed state to Disarmed, with a breakpoint request.

Each channel has a sticky status flag that records which channel caused a hit transition.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset `seq_state` is 0 (Disarmed), and `hit_flags`, `brk_req` and `tag_attach` are all zero.
- R2: An `arm` pulse moves any state to Armed-1 on the next edge and clears `hit_flags`. It also discards forced matches still in the delay line and all queued tag slots. `arm` overrides every other input in the same cycle.
- R3: In Disarmed and in Final, match pulses and execute strobes change neither `seq_state` nor `hit_flags`. In Disarmed a software trigger is also ignored, and `brk_req` stays 0.
- R4: A channel with `ch_tag_mode` bit 0 is in forced mode. When such a channel pulses in an armed state, the new state appears three cycles after the pulse cycle, and the state is unchanged two cycles after it. The channel's bit in `hit_flags` is set. `fetch_valid` plays no part in this.
- R5: The next state for armed state s (1..3) and channel c is held in the 2-bit field `next_cfg[((s-1)*NUM_CH+c)*2 +: 2]`. The codes map as 0→Armed-1, 1→Armed-2, 2→Armed-3 and 3→Final.
- R6: In an armed state, a cycle with `fetch_valid` and a pulse on a channel whose `ch_tag_mode` bit is 1 raises that bit of `tag_attach` in the same cycle. The tag is stored with that fetch slot. A tagged-mode pulse never causes a forced transition.
- R7: Each `exec_strobe` takes the oldest fetch slot. If the slot carries a tag, the sequencer moves on that edge and sets the flag. A slot without a tag does nothing. A strobe with no slot queued does nothing.
- R8: At most `TAGQ_DEPTH` fetch slots are held. A fetch that arrives while the queue is full and nothing is popped is dropped.
- R9: When several channels hit in the same cycle, the lowest-numbered channel wins, and only its flag is set.
- R10: A tag hit and a forced hit that mature on the same edge resolve to the tag hit. The forced hit is discarded.
- R11: With `end_align`=0, a `sw_trig` in any non-disarmed state moves to Final on the next edge without changing `hit_flags`. This takes priority over hits.
- R12: With `end_align`=1, a `sw_trig` in any non-disarmed state moves to Disarmed and raises `brk_req` for exactly one cycle. This takes priority over hits.
- R13: `hit_flags` bits only accumulate until the next `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Arm pulse: enter Armed-1 and clear flags |
| ch_match | input | NUM_CH | Per-channel comparator match pulses |
| ch_tag_mode | input | NUM_CH | Per-channel mode, 0 forced, 1 tagged |
| fetch_valid | input | 1 | An instruction fetch occurs this cycle |
| exec_strobe | input | 1 | The oldest fetched instruction executes |
| sw_trig | input | 1 | Software trigger write |
| end_align | input | 1 | 0 begin-aligned, 1 end-aligned session |
| next_cfg | input | 3*NUM_CH*2 | Next-state fields per armed state and channel |
| seq_state | output | 3 | Current state code |
| hit_flags | output | NUM_CH | Sticky per-channel hit flags |
| tag_attach | output | NUM_CH | Tag marks for the instruction being fetched |
| brk_req | output | 1 | One-cycle breakpoint request |

## Verification
The bench sweeps every armed state, every channel and every next-state code in both forced and tagged mode. This exposes a miswired configuration field or a lookup that uses the wrong state. It samples the state one cycle early as well as on time, so a delay line that is one stage too short or too long shows up as a state that changes early or late. Directed cases cover the following:
- a tag hit and a forced hit on the same edge, where a wrong priority ends in the forced target;
- a queue overflow, where a design that keeps the extra slot would move on a later strobe;
- slots without tags in front of a tagged slot;
- an arm while a forced match is still in the delay line, which a non-flushing design would act on after arming;
- the two trigger alignments, including a trigger in the same cycle as a tag hit.

// File: rtl/dts_pkg.sv
package dts_pkg;

    localparam int NUM_ARMED = 3;
    localparam int CFG_FLD_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM1  = 3'd1,
        ST_ARM2  = 3'd2,
        ST_ARM3  = 3'd3,
        ST_FINAL = 3'd4
    } seq_state_t;

    function automatic seq_state_t code_to_state(input logic [CFG_FLD_W-1:0] code);
        seq_state_t s;
        case (code)
            2'd0:    s = ST_ARM1;
            2'd1:    s = ST_ARM2;
            2'd2:    s = ST_ARM3;
            default: s = ST_FINAL;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dts_force_pipe.sv
module dts_force_pipe #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else if (flush) begin
            stg <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

    // R2: a flush leaves no pending forced match
    a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (dout == '0))
        else $error("forced delay line not emptied by flush");

endmodule

// File: rtl/dts_tag_fifo.sv
module dts_tag_fifo #(
    parameter int W     = 3,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         pop_valid,
    output logic [W-1:0] pop_data
);

    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] count;
    logic          do_pop;
    logic          do_push;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PW'(1);
    endfunction

    assign do_pop    = pop && (count != '0);
    assign do_push   = push && ((count != FULL_CNT) || do_pop);
    assign pop_valid = do_pop;
    assign pop_data  = slot[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot[i] <= '0;
            end
        end else if (do_push && !flush) begin
            slot[wr_ptr] <= push_data;
        end
    end

    // R8: occupancy never exceeds the slot count
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT)
        else $error("tag queue occupancy above depth");

    // R8: a fetch into a full queue without a pop is dropped
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && push && !pop && !flush) |=> (count == FULL_CNT))
        else $error("full tag queue changed occupancy on push");

    // R7: an execute strobe on an empty queue removes nothing
    a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop && !push && !flush) |=> (count == '0))
        else $error("empty tag queue changed on pop");

endmodule

// File: rtl/dts_prio_pick.sv
module dts_prio_pick #(
    parameter int W  = 3,
    parameter int IW = 2
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [W-1:0]  grant,
    output logic [IW-1:0] idx
);

    logic [W:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign any = seen[W];

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq #(
    parameter int NUM_CH       = 3,
    parameter int TAGQ_DEPTH   = 4,
    parameter int FORCE_STAGES = 2
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         arm,
    input  logic [NUM_CH-1:0]                            ch_match,
    input  logic [NUM_CH-1:0]                            ch_tag_mode,
    input  logic                                         fetch_valid,
    input  logic                                         exec_strobe,
    input  logic                                         sw_trig,
    input  logic                                         end_align,
    input  logic [dts_pkg::NUM_ARMED*NUM_CH*dts_pkg::CFG_FLD_W-1:0] next_cfg,
    output logic [2:0]                                   seq_state,
    output logic [NUM_CH-1:0]                            hit_flags,
    output logic [NUM_CH-1:0]                            tag_attach,
    output logic                                         brk_req
);
    import dts_pkg::*;

    localparam int CH_IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    seq_state_t state;
    seq_state_t nxt;
    logic       armed;
    logic [1:0] st_idx;

    logic [CFG_FLD_W-1:0] cfg_fld [NUM_ARMED][NUM_CH];

    for (genvar s = 0; s < NUM_ARMED; s++) begin : g_cfg_s
        for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg_c
            assign cfg_fld[s][c] = next_cfg[(s*NUM_CH + c)*CFG_FLD_W +: CFG_FLD_W];
        end
    end

    assign armed  = (state == ST_ARM1) || (state == ST_ARM2) || (state == ST_ARM3);
    assign st_idx = state[1:0] - 2'd1;

    // forced path
    logic [NUM_CH-1:0] forced_in;
    logic [NUM_CH-1:0] forced_due;

    assign forced_in = ch_match & ~ch_tag_mode;

    dts_force_pipe #(.W(NUM_CH), .STAGES(FORCE_STAGES)) u_fpipe (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (arm),
        .din   (forced_in),
        .dout  (forced_due)
    );

    // tagged path
    logic              q_valid;
    logic [NUM_CH-1:0] q_data;
    logic [NUM_CH-1:0] tag_due;

    assign tag_attach = (fetch_valid && armed) ? (ch_match & ch_tag_mode) : '0;

    dts_tag_fifo #(.W(NUM_CH), .DEPTH(TAGQ_DEPTH)) u_tagq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (arm),
        .push      (fetch_valid && armed),
        .push_data (tag_attach),
        .pop       (exec_strobe),
        .pop_valid (q_valid),
        .pop_data  (q_data)
    );

    assign tag_due = q_valid ? q_data : '0;

    logic              t_any, f_any;
    logic [NUM_CH-1:0] t_grant, f_grant;
    logic [CH_IW-1:0]  t_idx, f_idx;

    dts_prio_pick #(.W(NUM_CH), .IW(CH_IW)) u_tpick (
        .req   (tag_due),
        .any   (t_any),
        .grant (t_grant),
        .idx   (t_idx)
    );

    dts_prio_pick #(.W(NUM_CH), .IW(CH_IW)) u_fpick (
        .req   (forced_due),
        .any   (f_any),
        .grant (f_grant),
        .idx   (f_idx)
    );

    // next-state decision
    logic [NUM_CH-1:0] flag_set;
    logic              brk_set;

    always_comb begin
        nxt      = state;
        flag_set = '0;
        brk_set  = 1'b0;
        if (arm) begin
            nxt = ST_ARM1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    nxt = ST_IDLE;
                end
                ST_ARM1, ST_ARM2, ST_ARM3: begin
                    if (sw_trig) begin
                        if (end_align) begin
                            nxt     = ST_IDLE;
                            brk_set = 1'b1;
                        end else begin
                            nxt = ST_FINAL;
                        end
                    end else if (t_any) begin
                        nxt      = code_to_state(cfg_fld[st_idx][t_idx]);
                        flag_set = t_grant;
                    end else if (f_any) begin
                        nxt      = code_to_state(cfg_fld[st_idx][f_idx]);
                        flag_set = f_grant;
                    end
                end
                ST_FINAL: begin
                    if (sw_trig && end_align) begin
                        nxt     = ST_IDLE;
                        brk_set = 1'b1;
                    end
                end
                default: begin
                    nxt = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_flags <= '0;
            brk_req   <= 1'b0;
        end else begin
            hit_flags <= arm ? '0 : (hit_flags | flag_set);
            brk_req   <= brk_set;
        end
    end

    assign seq_state = state;

    // R3: disarmed state is left only by arming
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !arm) |=> (state == ST_IDLE && $stable(hit_flags) && !brk_req))
        else $error("disarmed state reacted to stimulus");

    // R3: final state ignores hits
    a_r3_final_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINAL && !arm && !(sw_trig && end_align)) |=> (state == ST_FINAL && $stable(hit_flags)))
        else $error("final state reacted to a hit");

    // R2: arming lands in Armed-1 with flags cleared
    a_r2_arm_enters: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (state == ST_ARM1 && hit_flags == '0 && !brk_req))
        else $error("arm did not restart the sequencer");

    // R11: begin-aligned trigger reaches Final
    a_r11_begin_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && sw_trig && !end_align && state != ST_IDLE) |=> (state == ST_FINAL))
        else $error("begin-aligned trigger missed Final");

    // R12: end-aligned trigger disarms and requests a break
    a_r12_end_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && sw_trig && end_align && state != ST_IDLE) |=> (state == ST_IDLE && brk_req))
        else $error("end-aligned trigger did not disarm with break");

    // R12: the breakpoint request is a single-cycle pulse
    a_r12_brk_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !brk_req)
        else $error("breakpoint request held longer than a cycle");

    // R13: flags only accumulate between arms
    a_r13_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> ((hit_flags & $past(hit_flags)) == $past(hit_flags)))
        else $error("hit flag dropped without arm");

    // R9: at most one channel flag is added per transition
    a_r9_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_set))
        else $error("more than one channel won a transition");

endmodule

// File: tb/sim_dbg_trig_seq.sv
module sim_dbg_trig_seq;

    localparam int CLK_P = 10;
    localparam int NC    = 3;
    localparam int CFGW  = 3 * NC * 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            arm = 1'b0;
    logic [NC-1:0]   ch_match = '0;
    logic [NC-1:0]   ch_tag_mode = '0;
    logic            fetch_valid = 1'b0;
    logic            exec_strobe = 1'b0;
    logic            sw_trig = 1'b0;
    logic            end_align = 1'b0;
    logic [CFGW-1:0] next_cfg = '0;
    logic [2:0]      seq_state;
    logic [NC-1:0]   hit_flags;
    logic [NC-1:0]   tag_attach;
    logic            brk_req;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_P/2) clk = ~clk;

    dbg_trig_seq #(.NUM_CH(NC), .TAGQ_DEPTH(4), .FORCE_STAGES(2)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .ch_match    (ch_match),
        .ch_tag_mode (ch_tag_mode),
        .fetch_valid (fetch_valid),
        .exec_strobe (exec_strobe),
        .sw_trig     (sw_trig),
        .end_align   (end_align),
        .next_cfg    (next_cfg),
        .seq_state   (seq_state),
        .hit_flags   (hit_flags),
        .tag_attach  (tag_attach),
        .brk_req     (brk_req)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int st_of(input int k);
        return (k == 3) ? 4 : k + 1;
    endfunction

    task automatic set_cfg(input int s, input int c, input int k);
        next_cfg[((s-1)*NC + c)*2 +: 2] = 2'(k);
    endtask

    task automatic do_arm();
        arm = 1'b1;
        tick();
        arm = 1'b0;
    endtask

    task automatic fire_forced(input int c);
        ch_match = NC'(1 << c);
        tick();
        ch_match = '0;
        tick();
        tick();
    endtask

    task automatic goto_state(input int s);
        ch_tag_mode = '0;
        next_cfg    = '0;
        do_arm();
        if (s > 1) begin
            set_cfg(1, 0, s - 1);
            fire_forced(0);
        end
    endtask

    task automatic fetch(input logic [NC-1:0] m);
        fetch_valid = 1'b1;
        ch_match    = m;
        tick();
        fetch_valid = 1'b0;
        ch_match    = '0;
    endtask

    task automatic execute();
        exec_strobe = 1'b1;
        tick();
        exec_strobe = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int base;
        // R1 reset state
        tick();
        tick();
        check("R1 state", int'(seq_state), 0);
        check("R1 flags", int'(hit_flags), 0);
        check("R1 brk", int'(brk_req), 0);
        rst_n = 1'b1;
        tick();
        check("R1 state after release", int'(seq_state), 0);
        fetch_valid = 1'b1;
        ch_match    = '1;
        ch_tag_mode = '1;
        #1;
        check("R1 tag_attach disarmed", int'(tag_attach), 0);
        fetch_valid = 1'b0;
        ch_match    = '0;
        ch_tag_mode = '0;

        // R3 disarmed ignores everything
        set_cfg(1, 0, 3);
        fire_forced(0);
        check("R3 idle forced state", int'(seq_state), 0);
        check("R3 idle forced flags", int'(hit_flags), 0);
        sw_trig = 1'b1;
        tick();
        sw_trig = 1'b0;
        check("R3 idle sw_trig state", int'(seq_state), 0);
        check("R3 idle sw_trig brk", int'(brk_req), 0);
        execute();
        check("R3 idle exec state", int'(seq_state), 0);

        // R4 / R5 forced sweep
        for (int s = 1; s <= 3; s++) begin
            for (int c = 0; c < NC; c++) begin
                for (int k = 0; k < 4; k++) begin
                    goto_state(s);
                    base = (s > 1) ? 1 : 0;
                    set_cfg(s, c, k);
                    ch_match = NC'(1 << c);
                    tick();
                    ch_match = '0;
                    tick();
                    check("R4 forced not early", int'(seq_state), s);
                    tick();
                    check("R5 forced target", int'(seq_state), st_of(k));
                    check("R4 forced flag", int'(hit_flags), base | (1 << c));
                end
            end
        end

        // R6 / R7 tagged sweep
        for (int s = 1; s <= 3; s++) begin
            for (int c = 0; c < NC; c++) begin
                for (int k = 0; k < 4; k++) begin
                    goto_state(s);
                    base = (s > 1) ? 1 : 0;
                    set_cfg(s, c, k);
                    ch_tag_mode = NC'(1 << c);
                    fetch_valid = 1'b1;
                    ch_match    = NC'(1 << c);
                    #1;
                    check("R6 tag_attach", int'(tag_attach), 1 << c);
                    tick();
                    fetch_valid = 1'b0;
                    ch_match    = '0;
                    tick();
                    tick();
                    tick();
                    check("R6 no forced from tag", int'(seq_state), s);
                    execute();
                    check("R7 tag hit target", int'(seq_state), st_of(k));
                    check("R7 tag hit flag", int'(hit_flags), base | (1 << c));
                    ch_tag_mode = '0;
                end
            end
        end

        // R9 lowest channel wins, forced and tagged
        goto_state(1);
        set_cfg(1, 1, 1);
        set_cfg(1, 2, 2);
        ch_match = 3'b110;
        tick();
        ch_match = '0;
        tick();
        tick();
        check("R9 forced prio state", int'(seq_state), 2);
        check("R9 forced prio flag", int'(hit_flags), 2);
        goto_state(1);
        set_cfg(1, 1, 1);
        set_cfg(1, 2, 2);
        ch_tag_mode = '1;
        fetch(3'b110);
        execute();
        check("R9 tag prio state", int'(seq_state), 2);
        check("R9 tag prio flag", int'(hit_flags), 2);

        // R10 tag hit beats same-edge forced hit
        goto_state(1);
        set_cfg(1, 0, 2);
        set_cfg(1, 1, 1);
        ch_tag_mode = 3'b001;
        fetch(3'b001);
        ch_match = 3'b010;
        tick();
        ch_match = '0;
        tick();
        exec_strobe = 1'b1;
        tick();
        exec_strobe = 1'b0;
        check("R10 tag wins state", int'(seq_state), 3);
        tick();
        tick();
        tick();
        check("R10 forced dropped state", int'(seq_state), 3);
        check("R10 forced dropped flag", int'(hit_flags), 1);

        // R7 empty pop and untagged slots; R8 overflow drop
        goto_state(1);
        set_cfg(1, 0, 3);
        ch_tag_mode = 3'b001;
        execute();
        check("R7 empty exec", int'(seq_state), 1);
        fetch(3'b000);
        fetch(3'b000);
        fetch(3'b000);
        fetch(3'b001);
        execute();
        execute();
        execute();
        check("R7 untagged slots", int'(seq_state), 1);
        execute();
        check("R7 tagged slot after untagged", int'(seq_state), 4);
        goto_state(1);
        set_cfg(1, 0, 3);
        ch_tag_mode = 3'b001;
        for (int i = 0; i < 4; i++) fetch(3'b000);
        fetch(3'b001);
        for (int i = 0; i < 5; i++) execute();
        check("R8 overflow dropped state", int'(seq_state), 1);
        check("R8 overflow dropped flag", int'(hit_flags), 0);
        ch_tag_mode = '0;

        // R11 begin trigger, R3 final ignores
        goto_state(2);
        end_align = 1'b0;
        sw_trig   = 1'b1;
        tick();
        sw_trig = 1'b0;
        check("R11 begin trig state", int'(seq_state), 4);
        check("R11 begin trig flags", int'(hit_flags), 1);
        check("R11 begin trig no brk", int'(brk_req), 0);
        fire_forced(1);
        check("R3 final forced state", int'(seq_state), 4);
        check("R3 final forced flags", int'(hit_flags), 1);
        sw_trig = 1'b1;
        tick();
        sw_trig = 1'b0;
        check("R11 begin trig in final", int'(seq_state), 4);

        // R12 end trigger from armed and from final
        end_align = 1'b1;
        sw_trig   = 1'b1;
        tick();
        sw_trig = 1'b0;
        check("R12 end trig from final state", int'(seq_state), 0);
        check("R12 end trig from final brk", int'(brk_req), 1);
        tick();
        check("R12 brk one cycle", int'(brk_req), 0);
        goto_state(3);
        sw_trig = 1'b1;
        tick();
        sw_trig = 1'b0;
        check("R12 end trig armed state", int'(seq_state), 0);
        check("R12 end trig armed brk", int'(brk_req), 1);
        goto_state(1);
        set_cfg(1, 0, 3);
        ch_tag_mode = 3'b001;
        fetch(3'b001);
        exec_strobe = 1'b1;
        sw_trig     = 1'b1;
        tick();
        exec_strobe = 1'b0;
        sw_trig     = 1'b0;
        check("R12 trig beats tag state", int'(seq_state), 0);
        check("R12 trig beats tag flags", int'(hit_flags), 0);
        end_align   = 1'b0;
        ch_tag_mode = '0;

        // R2 arm flushes pending work and beats trigger
        goto_state(1);
        set_cfg(1, 0, 3);
        ch_match = 3'b001;
        tick();
        ch_match = '0;
        do_arm();
        tick();
        tick();
        check("R2 flushed forced state", int'(seq_state), 1);
        check("R2 flushed forced flags", int'(hit_flags), 0);
        ch_tag_mode = 3'b001;
        fetch(3'b001);
        do_arm();
        execute();
        check("R2 flushed tag queue", int'(seq_state), 1);
        ch_tag_mode = '0;
        end_align   = 1'b1;
        sw_trig     = 1'b1;
        arm         = 1'b1;
        tick();
        arm       = 1'b0;
        sw_trig   = 1'b0;
        end_align = 1'b0;
        check("R2 arm beats trig state", int'(seq_state), 1);
        check("R2 arm beats trig brk", int'(brk_req), 0);

        // R13 flags accumulate, then clear on arm
        goto_state(1);
        set_cfg(1, 0, 1);
        fire_forced(0);
        set_cfg(2, 1, 2);
        fire_forced(1);
        check("R13 sticky state", int'(seq_state), 3);
        check("R13 sticky flags", int'(hit_flags), 3);
        do_arm();
        check("R2 arm clears flags", int'(hit_flags), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule